// File: doc/BRIEF.md
# Way-Predicted Four-Way Cache Lookup

This block is the lookup path of a small four-way set-associative cache. Each set keeps a two-bit guess of the way most likely to be used next. An accepted lookup first reads and compares only the guessed way. When the guess is right, the response appears in the first cycle after acceptance. When the guess is wrong, a second cycle compares the other three ways. That cycle reports either a hit, flagged as mispredicted, or a miss.

Lines are written through a fill port, which stands in for refill from the next level of memory. A fill goes into a way that already holds the same tag, if there is one. Otherwise it goes into the lowest-numbered invalid way, and otherwise into the way named by a three-bit tree pseudo-LRU. Every hit and every fill retrains the set's guess and its replacement tree. The block handles one operation at a time, and a fill takes priority over a lookup offered in the same cycle.

Top module: `waypred_cache`

## Requirements
- R1: After reset, every line is invalid, so every lookup misses. `req_ready` and `fill_ready` are 1 and `resp_valid` is 0.
- R2: An address splits into byte offset bits [1:0], set bits [3:2] and tag bits [ADDR_W-1:4]. The offset has no effect on a lookup.
- R3: If the guessed way holds the tag, the response comes in the first cycle after acceptance with `resp_hit`=1, `resp_mispredict`=0 and the line in `resp_data`.
- R4: If another way holds the tag, the response comes in the second cycle after acceptance with `resp_hit`=1, `resp_mispredict`=1 and the line.
- R5: If no way holds the tag, the response comes in the second cycle with `resp_hit`=0, `resp_mispredict`=0 and `resp_data`=0.
- R6: After a hit, the set's guess points at the way that hit, so an immediate repeat lookup of that line answers in one cycle.
- R7: After a fill, the set's guess points at the filled way, so a lookup of that line answers in one cycle.
- R8: A fill with a new tag takes the lowest-numbered invalid way of its set, so lines already present in the set stay present.
- R9: When the set is full, a fill evicts the pseudo-LRU victim. The tree has a root bit (0: ways 0-1, 1: ways 2-3) and one leaf bit per pair (0: lower way). Touching a way points the bits away from it, and every hit and every fill touches the way used.
- R10: A fill whose tag is already present in the set overwrites that way's data and evicts nothing.
- R11: A fill offered in an idle cycle is taken and drops `req_ready` for that cycle. A fill offered while a lookup is in progress sees `fill_ready`=0 and is ignored.
- R12: `resp_valid` lasts exactly one cycle. `req_ready` is 0 from acceptance until the response cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Lookup accepted at this edge when req_valid is high |
| fill_valid | input | 1 | Line write offered |
| fill_addr | input | ADDR_W | Address of the line to write |
| fill_data | input | DATA_W | Line contents |
| fill_ready | output | 1 | Fill taken at this edge when fill_valid is high |
| resp_valid | output | 1 | Lookup result present this cycle |
| resp_hit | output | 1 | Result is a hit |
| resp_mispredict | output | 1 | Hit found outside the guessed way |
| resp_data | output | DATA_W | Line on a hit, zero on a miss |

## Verification
A fill and a lookup can be offered in the same cycle. The bench provokes this by raising `fill_valid` and `req_valid` together in an idle cycle. It judges the outcome by `req_ready` reading 0 in that cycle and by the held request then hitting the new line in one cycle. The opposite collision is a fill raised while a lookup is in its probe cycle. There the bench checks that `fill_ready` is 0 and that a later lookup of that line misses.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int WPC_WAYS  = 4;
    localparam int WPC_WAY_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_SCAN  = 2'd2
    } cstate_e;

    // Move the tree bits {leaf_hi, leaf_lo, root} away from a used way.
    function automatic logic [2:0] plru_touch(input logic [2:0] bits, input logic [1:0] way);
        logic [2:0] r;
        r = bits;
        if (way[1] == 1'b0) begin
            r[0] = 1'b1;
            r[1] = ~way[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~way[0];
        end
        return r;
    endfunction

    function automatic logic [1:0] onehot_index(input logic [WPC_WAYS-1:0] vec);
        logic [1:0] r;
        r = '0;
        for (int i = 0; i < WPC_WAYS; i++) begin
            if (vec[i]) r = i[1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/wpc_way_match.sv
module wpc_way_match #(
    parameter int TAG_W = 12,
    parameter int WAYS  = 4
) (
    input  logic [WAYS-1:0]            line_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]           look_tag,
    input  logic [WAYS-1:0]            skip,
    output logic [WAYS-1:0]            match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = line_valid[w] && !skip[w] && (line_tag[w] == look_tag);
    end
endmodule

// File: rtl/wpc_victim_sel.sv
module wpc_victim_sel
    import wpc_pkg::*;
(
    input  logic [WPC_WAYS-1:0] line_valid,
    input  logic [2:0]          tree,
    output logic [1:0]          victim
);
    logic [1:0] free_way;
    logic       has_free;
    logic [1:0] lru_way;

    always_comb begin
        free_way = '0;
        has_free = 1'b0;
        for (int i = WPC_WAYS - 1; i >= 0; i--) begin
            if (!line_valid[i]) begin
                free_way = i[1:0];
                has_free = 1'b1;
            end
        end
        lru_way = tree[0] ? {1'b1, tree[2]} : {1'b0, tree[1]};
        victim  = has_free ? free_way : lru_way;
    end
endmodule

// File: rtl/waypred_cache.sv
module waypred_cache
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              fill_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_mispredict,
    output logic [DATA_W-1:0] resp_data
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    typedef struct packed {
        cstate_e                                         st;
        logic [ADDR_W-1:0]                               addr;
        logic [SETS-1:0][WPC_WAYS-1:0]                   vld;
        logic [SETS-1:0][WPC_WAYS-1:0][TAG_W-1:0]        tag;
        logic [SETS-1:0][WPC_WAYS-1:0][DATA_W-1:0]       dat;
        logic [SETS-1:0][WPC_WAY_W-1:0]                  pred;
        logic [SETS-1:0][2:0]                            plru;
    } cache_state_t;

    cache_state_t s_q, s_d;

    logic [SET_W-1:0]    req_set_q, fill_set, cmp_set;
    logic [TAG_W-1:0]    req_tag_q, fill_tag, cmp_tag;
    logic [WPC_WAYS-1:0] skip_vec, match_vec;
    logic [1:0]          guess_q, victim_way;
    logic                probe_hit;

    assign req_set_q = s_q.addr[OFF_W +: SET_W];
    assign req_tag_q = s_q.addr[ADDR_W-1 -: TAG_W];
    assign fill_set  = fill_addr[OFF_W +: SET_W];
    assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];
    assign guess_q   = s_q.pred[req_set_q];

    // The idle cycle shares the comparators with the fill path; the scan cycle uses them for the request.
    assign cmp_set  = (s_q.st == ST_IDLE) ? fill_set : req_set_q;
    assign cmp_tag  = (s_q.st == ST_IDLE) ? fill_tag : req_tag_q;
    assign skip_vec = (s_q.st == ST_SCAN) ? (WPC_WAYS'(1) << guess_q) : '0;

    // Single comparator of the probe cycle.
    assign probe_hit = s_q.vld[req_set_q][guess_q] && (s_q.tag[req_set_q][guess_q] == req_tag_q);

    wpc_way_match #(.TAG_W(TAG_W), .WAYS(WPC_WAYS)) u_match (
        .line_valid (s_q.vld[cmp_set]),
        .line_tag   (s_q.tag[cmp_set]),
        .look_tag   (cmp_tag),
        .skip       (skip_vec),
        .match      (match_vec)
    );

    wpc_victim_sel u_victim (
        .line_valid (s_q.vld[fill_set]),
        .tree       (s_q.plru[fill_set]),
        .victim     (victim_way)
    );

    assign req_ready  = (s_q.st == ST_IDLE) && !fill_valid;
    assign fill_ready = (s_q.st == ST_IDLE);

    always_comb begin
        logic [1:0] way;
        s_d             = s_q;
        resp_valid      = 1'b0;
        resp_hit        = 1'b0;
        resp_mispredict = 1'b0;
        resp_data       = '0;
        way             = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (fill_valid) begin
                    way = (|match_vec) ? onehot_index(match_vec) : victim_way;
                    s_d.vld[fill_set][way]  = 1'b1;
                    s_d.tag[fill_set][way]  = fill_tag;
                    s_d.dat[fill_set][way]  = fill_data;
                    s_d.pred[fill_set]      = way;
                    s_d.plru[fill_set]      = plru_touch(s_q.plru[fill_set], way);
                end else if (req_valid) begin
                    s_d.addr = req_addr;
                    s_d.st   = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (probe_hit) begin
                    resp_valid          = 1'b1;
                    resp_hit            = 1'b1;
                    resp_data           = s_q.dat[req_set_q][guess_q];
                    s_d.plru[req_set_q] = plru_touch(s_q.plru[req_set_q], guess_q);
                    s_d.st              = ST_IDLE;
                end else begin
                    s_d.st = ST_SCAN;
                end
            end
            ST_SCAN: begin
                resp_valid = 1'b1;
                s_d.st     = ST_IDLE;
                if (|match_vec) begin
                    way                 = onehot_index(match_vec);
                    resp_hit            = 1'b1;
                    resp_mispredict     = 1'b1;
                    resp_data           = s_q.dat[req_set_q][way];
                    s_d.pred[req_set_q] = way;
                    s_d.plru[req_set_q] = plru_touch(s_q.plru[req_set_q], way);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R12: a result is shown for one cycle only
    a_r12_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R12: accepting a lookup closes both input ports for the next cycle
    a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !fill_ready));

    // R4: a mispredict flag only accompanies a hit result
    a_r4_mispredict_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        resp_mispredict |-> (resp_valid && resp_hit));

    // R10: fills never create two ways with the same tag in a set
    a_r10_no_dup_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SCAN) |-> $onehot0(match_vec));

    // R11: a fill offered during a lookup leaves the arrays untouched
    a_r11_fill_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (s_q.st != ST_IDLE)) |=> $stable(s_q.vld) && $stable(s_q.dat));

    // R5: a miss result carries no data
    a_r5_miss_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_data == '0 && !resp_mispredict));

endmodule

// File: tb/sim_waypred_cache.sv
module sim_waypred_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          fill_ready;
    logic          resp_valid, resp_hit, resp_mispredict;
    logic [DW-1:0] resp_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    waypred_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) u0 (
        .clk, .rst_n, .req_valid, .req_addr, .req_ready,
        .fill_valid, .fill_addr, .fill_data, .fill_ready,
        .resp_valid, .resp_hit, .resp_mispredict, .resp_data
    );

    function automatic logic [AW-1:0] mk(input logic [11:0] tag, input logic [1:0] set, input logic [1:0] off);
        return {tag, set, off};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Issue a lookup and check hit, latency, mispredict flag and data.
    task automatic lookup(input logic [AW-1:0] a, input bit e_hit, input int e_lat, input bit e_mp,
                          input logic [DW-1:0] e_data, input string req);
        int lat;
        bit h, mp;
        logic [DW-1:0] d;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        #1;
        check(req_ready == 1'b1, req, "req_ready before accept", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (!resp_valid) begin
            @(negedge clk);
            lat = resp_valid ? 2 : 3;
        end
        h = resp_hit; mp = resp_mispredict; d = resp_data;
        check(lat == e_lat, req, "latency", 64'(lat), 64'(e_lat));
        check(h == e_hit && mp == e_mp && d == e_data, req, "hit/mispredict/data",
              {31'd0, h, mp, d}, {31'd0, e_hit, e_mp, e_data});
        @(negedge clk);
        check(!resp_valid && req_ready, "R12", "response single cycle, ready again",
              {62'd0, resp_valid, req_ready}, 64'd1);
    endtask

    localparam logic [11:0] TA = 12'h011, TB = 12'h022, TC = 12'h033, TD = 12'h044,
                            TE = 12'h055, TX = 12'h066, TY = 12'h077, TZ = 12'h088;

    task automatic t_reset();
        #1;
        check(req_ready && fill_ready && !resp_valid, "R1", "reset outputs",
              {61'd0, req_ready, fill_ready, resp_valid}, 64'h6);
        lookup(mk(TA, 2'd0, 2'd0), 1'b0, 2, 1'b0, '0, "R1");
    endtask

    task automatic t_first_fill();
        do_fill(mk(TA, 2'd0, 2'd0), 32'hA0A0_0001);
        lookup(mk(TA, 2'd0, 2'd0), 1'b1, 1, 1'b0, 32'hA0A0_0001, "R7");
        lookup(mk(TA, 2'd0, 2'd3), 1'b1, 1, 1'b0, 32'hA0A0_0001, "R2");
        lookup(mk(TA, 2'd1, 2'd0), 1'b0, 2, 1'b0, '0, "R2");
        lookup(mk(TB, 2'd0, 2'd0), 1'b0, 2, 1'b0, '0, "R5");
    endtask

    task automatic t_predict();
        do_fill(mk(TB, 2'd0, 2'd0), 32'hB0B0_0002);
        do_fill(mk(TC, 2'd0, 2'd0), 32'hC0C0_0003);
        do_fill(mk(TD, 2'd0, 2'd0), 32'hD0D0_0004);
        lookup(mk(TA, 2'd0, 2'd1), 1'b1, 2, 1'b1, 32'hA0A0_0001, "R4");
        lookup(mk(TA, 2'd0, 2'd2), 1'b1, 1, 1'b0, 32'hA0A0_0001, "R6");
        lookup(mk(TA, 2'd0, 2'd0), 1'b1, 1, 1'b0, 32'hA0A0_0001, "R3");
    endtask

    // Tree after fills into ways 0..3 is all zero; touching way 0 leaves way 2 as victim.
    task automatic t_plru();
        do_fill(mk(TE, 2'd0, 2'd0), 32'hE0E0_0005);
        lookup(mk(TC, 2'd0, 2'd0), 1'b0, 2, 1'b0, '0, "R9");
        lookup(mk(TE, 2'd0, 2'd0), 1'b1, 1, 1'b0, 32'hE0E0_0005, "R9");
        lookup(mk(TB, 2'd0, 2'd0), 1'b1, 2, 1'b1, 32'hB0B0_0002, "R9");
        lookup(mk(TD, 2'd0, 2'd0), 1'b1, 2, 1'b1, 32'hD0D0_0004, "R9");
        lookup(mk(TA, 2'd0, 2'd0), 1'b1, 2, 1'b1, 32'hA0A0_0001, "R9");
    endtask

    task automatic t_inplace();
        do_fill(mk(TA, 2'd0, 2'd0), 32'hA1A1_1111);
        lookup(mk(TA, 2'd0, 2'd0), 1'b1, 1, 1'b0, 32'hA1A1_1111, "R10");
        lookup(mk(TB, 2'd0, 2'd0), 1'b1, 2, 1'b1, 32'hB0B0_0002, "R10");
        lookup(mk(TD, 2'd0, 2'd0), 1'b1, 2, 1'b1, 32'hD0D0_0004, "R10");
        lookup(mk(TE, 2'd0, 2'd0), 1'b1, 2, 1'b1, 32'hE0E0_0005, "R10");
    endtask

    task automatic t_invalid_first();
        do_fill(mk(TX, 2'd1, 2'd0), 32'h6666_0006);
        do_fill(mk(TY, 2'd1, 2'd0), 32'h7777_0007);
        lookup(mk(TX, 2'd1, 2'd0), 1'b1, 2, 1'b1, 32'h6666_0006, "R8");
        lookup(mk(TY, 2'd1, 2'd0), 1'b1, 2, 1'b1, 32'h7777_0007, "R8");
    endtask

    task automatic t_collide();
        // Fill and lookup in the same idle cycle: fill wins, lookup waits.
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = mk(TZ, 2'd2, 2'd0); fill_data = 32'h8888_0008;
        req_valid = 1'b1;  req_addr = mk(TZ, 2'd2, 2'd1);
        #1;
        check(!req_ready && fill_ready, "R11", "fill blocks lookup", {62'd0, req_ready, fill_ready}, 64'h1);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check(req_ready, "R11", "lookup taken after fill", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid && resp_hit && !resp_mispredict && resp_data == 32'h8888_0008, "R11",
              "held lookup hits new line in one cycle", {29'd0, resp_valid, resp_hit, resp_mispredict, resp_data},
              {29'd0, 3'b110, 32'h8888_0008});
        // Fill during a lookup in progress is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk(TX, 2'd1, 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
        fill_valid = 1'b1; fill_addr = mk(TY, 2'd3, 2'd0); fill_data = 32'h9999_0009;
        #1;
        check(!fill_ready && !req_ready, "R12", "ports closed during lookup", {62'd0, fill_ready, req_ready}, 64'd0);
        @(negedge clk);
        fill_valid = 1'b0;
        @(negedge clk);
        lookup(mk(TY, 2'd3, 2'd0), 1'b0, 2, 1'b0, '0, "R11");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_fill();
        t_predict();
        t_plru();
        t_inplace();
        t_invalid_first();
        t_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule